// File: doc/BRIEF.md
# Pattern Block Sequencer

This block steers the address side of a digital pattern generator. A small program memory holds sequence lines. Each line points at a block of pattern memory through a base address and a length. It also gives a repeat count or a run-forever flag, an optional wait condition, the level to drive on an outgoing cross-module signal, and an optional conditional jump with a target line. Once started, the controller walks the lines and emits one pattern-memory address per clock with a valid strobe. A downstream pattern memory turns each address into output data.

Conditions are built from an event vector. Bits 7..0 of this vector are the external event inputs. Bit 8 is one of four incoming cross-module signals, chosen by a global setting. Each condition is either level-sensitive or sensitive to a false-to-true change. A step mode lets an operator push a pending wait or jump through by hand. Software loads lines and global settings through a simple write port. A global write with the run bit set restarts the program at line 0. A global write with the run bit clear halts it.

Top module: `pgseq_top`

## Requirements
- R1: After reset, and in the cycle after a global write with `cfg_run`=0, `pat_valid`, `done` and `ims_out` are all 0. A global write with `cfg_run`=1 restarts execution at line 0 from any state.
- R2: While a line runs, one word is emitted per cycle. `pat_valid` is 1 and `pat_addr` steps through `base`, `base`+1 … `base`+`len_m1`, so a block holds `len_m1`+1 words.
- R3: A block is emitted `rpt_m1`+1 times back to back, with `rpt_m1` 16 bits wide (1 to 65,536 passes). No gap cycle separates the passes or the following line. With `rpt_inf`=1 the block repeats until a jump, stop or restart.
- R4: When a line with `wait_en`=1 is entered, `pat_valid` stays 0 until the wait condition hits. The first word appears in the cycle after the hit cycle.
- R5: A condition is a level hit when every event-vector bit set in `care` equals the same bit of `want`. The vector is {`ims_in[cfg_ev_sel]`, `ev_in[7:0]`}, with the cross-module input at bit 8. With `edge_mode`=1, the condition hits only when the level hit is true now and was false in the previous cycle.
- R6: The jump condition of a line with `jmp_en`=1 is evaluated on the last word of every pass. On a hit, the next cycle starts line `jmp_tgt` (its first word, or its wait), and any remaining passes are dropped. A level condition with `care`=0 always hits, giving an unconditional jump.
- R7: An edge-mode jump hit in any cycle while the line waits or runs is held until the next last-word evaluation. It is cleared at that evaluation, even when it does not lead to a jump.
- R8: `ims_out[cfg_drive_sel]` carries the `sig_lvl` of the current line from the cycle that line is entered. The other bits of `ims_out` are always 0.
- R9: With `cfg_step`=1, a high `man_sat` satisfies a pending wait and counts as a jump hit on a last word. With `cfg_step`=0, `man_sat` has no effect.
- R10: When the final pass of line `cfg_last` ends without a jump, `pat_valid` goes to 0 and `done` goes to 1. Both hold until the next global write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_in | input | 8 | External event inputs, event-vector bits 7..0 |
| ims_in | input | 4 | Incoming cross-module signals |
| man_sat | input | 1 | Manual satisfy in step mode |
| cfg_line_we | input | 1 | Write one sequence line |
| cfg_line_idx | input | 4 | Line index for the write |
| cfg_line_data | input | LINE_W | Packed line fields (package struct `seq_line_t`) |
| cfg_glb_we | input | 1 | Write global settings and start or stop |
| cfg_run | input | 1 | 1: restart at line 0, 0: halt |
| cfg_step | input | 1 | Step mode enable |
| cfg_last | input | 4 | Index of the final line |
| cfg_drive_sel | input | 2 | Which `ims_out` bit the program drives |
| cfg_ev_sel | input | 2 | Which `ims_in` bit forms event-vector bit 8 |
| pat_addr | output | 10 | Pattern memory address |
| pat_valid | output | 1 | Address valid strobe |
| ims_out | output | 4 | Outgoing cross-module signals |
| done | output | 1 | Program finished |

## Verification
Several properties are checked on every cycle:
- addresses step by one inside a block;
- no word is emitted while a wait is unsatisfied;
- `done` excludes valid and holds until a global write;
- at most one outgoing signal is high;
- a stop clears all outputs.

Other behaviour shows only in the bench's scenarios, against a cycle model and fixed expected address lists:
- exact pass counts up to 65,536;
- dropped repeats on a jump;
- the held edge for a jump;
- step-mode satisfaction and the unconditional jump that skips an initial block.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  parameter int ADDR_W  = 10;
  parameter int RPT_W   = 16;
  parameter int EVT_W   = 8;
  parameter int N_LINES = 16;
  parameter int N_IMS   = 4;

  localparam int LIDX_W = $clog2(N_LINES);
  localparam int IMS_W  = $clog2(N_IMS);
  localparam int VEC_W  = EVT_W + 1;

  typedef struct packed {
    logic             edge_mode;
    logic [VEC_W-1:0] care;
    logic [VEC_W-1:0] want;
  } evt_cond_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] len_m1;
    logic [RPT_W-1:0]  rpt_m1;
    logic              rpt_inf;
    logic              wait_en;
    evt_cond_t         wait_c;
    logic              sig_lvl;
    logic              jmp_en;
    evt_cond_t         jmp_c;
    logic [LIDX_W-1:0] jmp_tgt;
  } seq_line_t;

  localparam int LINE_W = $bits(seq_line_t);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seq_st_t;
endpackage

// File: rtl/pgseq_store.sv
module pgseq_store
  import pgseq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       line_we_i,
  input  logic [LIDX_W-1:0]          line_idx_i,
  input  logic [LINE_W-1:0]          line_data_i,
  input  logic                       glb_we_i,
  input  logic                       step_i,
  input  logic [LIDX_W-1:0]          last_i,
  input  logic [IMS_W-1:0]           drive_sel_i,
  input  logic [IMS_W-1:0]           ev_sel_i,
  output seq_line_t [N_LINES-1:0]    lines_o,
  output logic                       step_o,
  output logic [LIDX_W-1:0]          last_o,
  output logic [IMS_W-1:0]           drive_sel_o,
  output logic [IMS_W-1:0]           ev_sel_o
);
  seq_line_t         mem_q [N_LINES];
  logic              step_q;
  logic [LIDX_W-1:0] last_q;
  logic [IMS_W-1:0]  drive_q;
  logic [IMS_W-1:0]  evsel_q;

  // program memory, write enable per line
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LINES; i++) mem_q[i] <= '0;
    end else if (line_we_i) begin
      mem_q[line_idx_i] <= seq_line_t'(line_data_i);
    end
  end

  // global settings, enabled by the global write
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= 1'b0;
      last_q  <= '0;
      drive_q <= '0;
      evsel_q <= '0;
    end else if (glb_we_i) begin
      step_q  <= step_i;
      last_q  <= last_i;
      drive_q <= drive_sel_i;
      evsel_q <= ev_sel_i;
    end
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_out
    assign lines_o[g] = mem_q[g];
  end

  assign step_o      = step_q;
  assign last_o      = last_q;
  assign drive_sel_o = drive_q;
  assign ev_sel_o    = evsel_q;
endmodule

// File: rtl/pgseq_cond.sv
module pgseq_cond
  import pgseq_pkg::*;
(
  input  evt_cond_t        cond_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [VEC_W-1:0] vec_prev_i,
  output logic             hit_o
);
  logic lvl_now;
  logic lvl_prev;

  always_comb begin
    lvl_now  = ((vec_i      ^ cond_i.want) & cond_i.care) == '0;
    lvl_prev = ((vec_prev_i ^ cond_i.want) & cond_i.care) == '0;
    hit_o    = cond_i.edge_mode ? (lvl_now & ~lvl_prev) : lvl_now;
  end
endmodule

// File: rtl/pgseq_ctrl.sv
module pgseq_ctrl
  import pgseq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  seq_line_t [N_LINES-1:0] lines_i,
  input  logic [LIDX_W-1:0]       last_i,
  input  logic                    man_ok_i,
  input  logic [VEC_W-1:0]        vec_i,
  input  logic [VEC_W-1:0]        vec_prev_i,
  output logic [ADDR_W-1:0]       pat_addr_o,
  output logic                    pat_valid_o,
  output logic                    sig_o,
  output logic                    done_o,
  output logic                    in_wait_o,
  output logic                    wait_hit_o,
  output logic                    mid_blk_o
);
  seq_st_t           st_q, st_n;
  logic [LIDX_W-1:0] cur_q, cur_n;
  logic [ADDR_W-1:0] off_q, off_n;
  logic [RPT_W-1:0]  rcnt_q, rcnt_n;
  logic              jpend_q, jpend_n;

  seq_line_t         cur_l;
  logic              wait_hit;
  logic              jmp_hit;
  logic              last_word;
  logic              jump_go;
  logic              jedge_seen;
  logic              enter;
  logic [LIDX_W-1:0] ent_idx;

  assign cur_l = lines_i[cur_q];

  // two copies of the condition evaluator: wait and jump
  pgseq_cond u_wait_cond (
    .cond_i     (cur_l.wait_c),
    .vec_i      (vec_i),
    .vec_prev_i (vec_prev_i),
    .hit_o      (wait_hit)
  );

  pgseq_cond u_jmp_cond (
    .cond_i     (cur_l.jmp_c),
    .vec_i      (vec_i),
    .vec_prev_i (vec_prev_i),
    .hit_o      (jmp_hit)
  );

  always_comb begin
    last_word  = (off_q == cur_l.len_m1);
    jump_go    = cur_l.jmp_en & (jmp_hit | jpend_q | man_ok_i);
    jedge_seen = cur_l.jmp_c.edge_mode & jmp_hit;
  end

  // next-state process
  always_comb begin
    st_n    = st_q;
    cur_n   = cur_q;
    off_n   = off_q;
    rcnt_n  = rcnt_q;
    jpend_n = jpend_q;
    enter   = 1'b0;
    ent_idx = cur_q;

    if (stop_i) begin
      st_n    = ST_IDLE;
      jpend_n = 1'b0;
    end else if (start_i) begin
      enter   = 1'b1;
      ent_idx = '0;
    end else begin
      case (st_q)
        ST_WAIT: begin
          jpend_n = jpend_q | jedge_seen;
          if (!cur_l.wait_en || wait_hit || man_ok_i) st_n = ST_RUN;
        end
        ST_RUN: begin
          if (last_word) begin
            if (jump_go) begin
              enter   = 1'b1;
              ent_idx = cur_l.jmp_tgt;
            end else if (cur_l.rpt_inf || (rcnt_q != cur_l.rpt_m1)) begin
              off_n   = '0;
              rcnt_n  = rcnt_q + RPT_W'(1);
              jpend_n = 1'b0;
            end else if (cur_q == last_i) begin
              st_n    = ST_DONE;
              jpend_n = 1'b0;
            end else begin
              enter   = 1'b1;
              ent_idx = cur_q + LIDX_W'(1);
            end
          end else begin
            off_n   = off_q + ADDR_W'(1);
            jpend_n = jpend_q | jedge_seen;
          end
        end
        default: ;
      endcase
    end

    if (enter) begin
      cur_n   = ent_idx;
      off_n   = '0;
      rcnt_n  = '0;
      jpend_n = 1'b0;
      st_n    = lines_i[ent_idx].wait_en ? ST_WAIT : ST_RUN;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      off_q   <= '0;
      rcnt_q  <= '0;
      jpend_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cur_q   <= cur_n;
      off_q   <= off_n;
      rcnt_q  <= rcnt_n;
      jpend_q <= jpend_n;
    end
  end

  assign pat_valid_o = (st_q == ST_RUN);
  assign pat_addr_o  = cur_l.base + off_q;
  assign sig_o       = (st_q != ST_IDLE) & cur_l.sig_lvl;
  assign done_o      = (st_q == ST_DONE);
  assign in_wait_o   = (st_q == ST_WAIT) & cur_l.wait_en;
  assign wait_hit_o  = wait_hit;
  assign mid_blk_o   = (st_q == ST_RUN) & ~last_word;
endmodule

// File: rtl/pgseq_top.sv
module pgseq_top
  import pgseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  ev_in,
  input  logic [N_IMS-1:0]  ims_in,
  input  logic              man_sat,
  input  logic              cfg_line_we,
  input  logic [LIDX_W-1:0] cfg_line_idx,
  input  logic [LINE_W-1:0] cfg_line_data,
  input  logic              cfg_glb_we,
  input  logic              cfg_run,
  input  logic              cfg_step,
  input  logic [LIDX_W-1:0] cfg_last,
  input  logic [IMS_W-1:0]  cfg_drive_sel,
  input  logic [IMS_W-1:0]  cfg_ev_sel,
  output logic [ADDR_W-1:0] pat_addr,
  output logic              pat_valid,
  output logic [N_IMS-1:0]  ims_out,
  output logic              done
);
  logic [1:0]              rst_sync_q;
  logic                    rst_sync_n;
  seq_line_t [N_LINES-1:0] lines;
  logic                    step_en;
  logic [LIDX_W-1:0]       last_idx;
  logic [IMS_W-1:0]        drive_sel;
  logic [IMS_W-1:0]        ev_sel;
  logic [VEC_W-1:0]        vec;
  logic [VEC_W-1:0]        vec_prev_q;
  logic                    man_ok;
  logic                    sig;
  logic                    in_wait;
  logic                    wait_hit;
  logic                    mid_blk;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pgseq_store u_store (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .line_we_i   (cfg_line_we),
    .line_idx_i  (cfg_line_idx),
    .line_data_i (cfg_line_data),
    .glb_we_i    (cfg_glb_we),
    .step_i      (cfg_step),
    .last_i      (cfg_last),
    .drive_sel_i (cfg_drive_sel),
    .ev_sel_i    (cfg_ev_sel),
    .lines_o     (lines),
    .step_o      (step_en),
    .last_o      (last_idx),
    .drive_sel_o (drive_sel),
    .ev_sel_o    (ev_sel)
  );

  assign vec    = {ims_in[ev_sel], ev_in};
  assign man_ok = step_en & man_sat;

  // previous event vector for change detection
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vec_prev_q <= '0;
    else             vec_prev_q <= vec;
  end

  pgseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .start_i     (cfg_glb_we & cfg_run),
    .stop_i      (cfg_glb_we & ~cfg_run),
    .lines_i     (lines),
    .last_i      (last_idx),
    .man_ok_i    (man_ok),
    .vec_i       (vec),
    .vec_prev_i  (vec_prev_q),
    .pat_addr_o  (pat_addr),
    .pat_valid_o (pat_valid),
    .sig_o       (sig),
    .done_o      (done),
    .in_wait_o   (in_wait),
    .wait_hit_o  (wait_hit),
    .mid_blk_o   (mid_blk)
  );

  for (genvar g = 0; g < N_IMS; g++) begin : g_ims
    assign ims_out[g] = sig & (drive_sel == IMS_W'(g));
  end
endmodule

// File: rtl/pgseq_chk.sv
module pgseq_chk
  import pgseq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pat_addr,
  input logic              pat_valid,
  input logic              done,
  input logic [N_IMS-1:0]  ims_out,
  input logic              cfg_glb_we,
  input logic              cfg_run,
  input logic              in_wait,
  input logic              wait_hit,
  input logic              man_ok,
  input logic              mid_blk
);
  a_r10_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pat_valid);

  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_glb_we) |=> done);

  a_r8_one_signal: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ims_out));

  a_r1_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_glb_we && !cfg_run) |=> (!pat_valid && !done && ims_out == '0));

  a_r2_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_blk && !cfg_glb_we) |=> (pat_valid && pat_addr == ADDR_W'($past(pat_addr) + 1'b1)));

  a_r4_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !wait_hit && !man_ok && !cfg_glb_we) |=> !pat_valid);
endmodule

bind pgseq_top pgseq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .pat_addr   (pat_addr),
  .pat_valid  (pat_valid),
  .done       (done),
  .ims_out    (ims_out),
  .cfg_glb_we (cfg_glb_we),
  .cfg_run    (cfg_run),
  .in_wait    (in_wait),
  .wait_hit   (wait_hit),
  .man_ok     (man_ok),
  .mid_blk    (mid_blk)
);

// File: tb/pgseq_tb.sv
`timescale 1ns/1ps
module pgseq_top_tb_top;
  import pgseq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [EVT_W-1:0]  ev_in = '0;
  logic [N_IMS-1:0]  ims_in = '0;
  logic              man_sat = 1'b0;
  logic              cfg_line_we = 1'b0;
  logic [LIDX_W-1:0] cfg_line_idx = '0;
  logic [LINE_W-1:0] cfg_line_data = '0;
  logic              cfg_glb_we = 1'b0;
  logic              cfg_run = 1'b0;
  logic              cfg_step = 1'b0;
  logic [LIDX_W-1:0] cfg_last = '0;
  logic [IMS_W-1:0]  cfg_drive_sel = '0;
  logic [IMS_W-1:0]  cfg_ev_sel = '0;
  logic [ADDR_W-1:0] pat_addr;
  logic              pat_valid;
  logic [N_IMS-1:0]  ims_out;
  logic              done;

  always #4 clk = ~clk;

  pgseq_top dut_i (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int obs_q[$];
  int word_cnt = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- bench model ----------------
  seq_line_t         b_line [N_LINES];
  logic [LIDX_W-1:0] b_last = '0;
  bit                b_step = 0;
  int                b_drv = 0;
  int                b_evsel = 0;
  bit                model_on = 0;
  int                m_st = 0, m_cur = 0, m_off = 0, m_rcnt = 0;
  bit                m_jp = 0;
  logic [VEC_W-1:0]  m_prev = '0;

  function automatic bit lvl_f(evt_cond_t c, logic [VEC_W-1:0] v);
    return ((v ^ c.want) & c.care) == '0;
  endfunction

  function automatic bit hit_f(evt_cond_t c, logic [VEC_W-1:0] v, logic [VEC_W-1:0] pv);
    if (c.edge_mode) return lvl_f(c, v) && !lvl_f(c, pv);
    return lvl_f(c, v);
  endfunction

  always @(posedge clk) begin
    if (model_on) begin
      seq_line_t cl;
      logic [VEC_W-1:0] v;
      bit wh, jh, man, ent;
      int ei, n_st, n_cur, n_off, n_rcnt;
      bit n_jp;
      v  = {ims_in[b_evsel], ev_in};
      cl = b_line[m_cur];
      wh = hit_f(cl.wait_c, v, m_prev);
      jh = hit_f(cl.jmp_c, v, m_prev);
      man = b_step && man_sat;
      n_st = m_st; n_cur = m_cur; n_off = m_off; n_rcnt = m_rcnt; n_jp = m_jp;
      ent = 0; ei = 0;
      if (cfg_glb_we && !cfg_run) begin n_st = 0; n_jp = 0; end
      else if (cfg_glb_we) begin ent = 1; ei = 0; end
      else if (m_st == 1) begin
        if (cl.jmp_c.edge_mode && jh) n_jp = 1;
        if (!cl.wait_en || wh || man) n_st = 2;
      end else if (m_st == 2) begin
        if (m_off == int'(cl.len_m1)) begin
          if (cl.jmp_en && (jh || m_jp || man)) begin ent = 1; ei = int'(cl.jmp_tgt); end
          else if (cl.rpt_inf || m_rcnt != int'(cl.rpt_m1)) begin
            n_off = 0; n_rcnt = (m_rcnt + 1) % 65536; n_jp = 0;
          end else if (m_cur == int'(b_last)) begin n_st = 3; n_jp = 0; end
          else begin ent = 1; ei = (m_cur + 1) % N_LINES; end
        end else begin
          n_off = m_off + 1;
          if (cl.jmp_c.edge_mode && jh) n_jp = 1;
        end
      end
      if (ent) begin
        n_cur = ei; n_off = 0; n_rcnt = 0; n_jp = 0;
        n_st = b_line[ei].wait_en ? 1 : 2;
      end
      m_st = n_st; m_cur = n_cur; m_off = n_off; m_rcnt = n_rcnt; m_jp = n_jp;
      m_prev = v;
      if (cfg_line_we) b_line[cfg_line_idx] = seq_line_t'(cfg_line_data);
      if (cfg_glb_we) begin
        b_step = cfg_step; b_last = cfg_last;
        b_drv = int'(cfg_drive_sel); b_evsel = int'(cfg_ev_sel);
      end
    end
  end

  // lockstep compare and word capture, away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      int ea;
      int ei;
      ea = (int'(b_line[m_cur].base) + m_off) % (1 << ADDR_W);
      ei = (m_st != 0 && b_line[m_cur].sig_lvl) ? (1 << b_drv) : 0;
      chk(pat_valid == (m_st == 2), "R2 R4 model pat_valid", pat_valid, m_st == 2);
      if (m_st == 2) chk(int'(pat_addr) == ea, "R2 R6 model pat_addr", pat_addr, ea);
      chk(done == (m_st == 3), "R10 model done", done, m_st == 3);
      chk(int'(ims_out) == ei, "R8 model ims_out", ims_out, ei);
      if (pat_valid) begin obs_q.push_back(int'(pat_addr)); word_cnt++; end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_line(input int idx, input seq_line_t l);
    @(negedge clk); #1;
    cfg_line_we = 1'b1; cfg_line_idx = LIDX_W'(idx); cfg_line_data = l;
    @(negedge clk); #1;
    cfg_line_we = 1'b0;
  endtask

  task automatic glb(input bit run, input bit step, input int last, input int drv, input int evs);
    @(negedge clk); #1;
    cfg_glb_we = 1'b1; cfg_run = run; cfg_step = step;
    cfg_last = LIDX_W'(last); cfg_drive_sel = IMS_W'(drv); cfg_ev_sel = IMS_W'(evs);
    if (run) begin obs_q.delete(); word_cnt = 0; end
    @(negedge clk); #1;
    cfg_glb_we = 1'b0;
  endtask

  task automatic clear_lines();
    for (int i = 0; i < N_LINES; i++) wr_line(i, '0);
  endtask

  function automatic seq_line_t mk(input int base, input int len_m1, input int rpt_m1);
    seq_line_t l;
    l = '0;
    l.base = ADDR_W'(base); l.len_m1 = ADDR_W'(len_m1); l.rpt_m1 = RPT_W'(rpt_m1);
    return l;
  endfunction

  task automatic chk_seq(input int exp[], input string tag);
    for (int i = 0; i < exp.size(); i++) begin
      if (i < obs_q.size()) chk(obs_q[i] == exp[i], tag, obs_q[i], exp[i]);
      else chk(0, tag, -1, exp[i]);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    seq_line_t l;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < N_LINES; i++) b_line[i] = '0;
    model_on = 1;
    // R1 reset state
    chk(pat_valid == 0, "R1 reset pat_valid", pat_valid, 0);
    chk(done == 0, "R1 reset done", done, 0);
    chk(ims_out == 0, "R1 reset ims_out", ims_out, 0);

    // R2 R3 R10: two passes of a 3-word block then a single word, then done
    wr_line(0, mk(100, 2, 1));
    wr_line(1, mk(200, 0, 0));
    glb(1, 0, 1, 0, 0);
    repeat (12) @(negedge clk);
    chk_seq('{100, 101, 102, 100, 101, 102, 200}, "R2 R3 block order");
    chk(obs_q.size() == 7, "R3 word count", obs_q.size(), 7);
    chk(done == 1, "R10 done after last line", done, 1);
    chk(pat_valid == 0, "R10 no valid when done", pat_valid, 0);

    // R1 stop clears
    glb(0, 0, 0, 0, 0);
    chk(done == 0 && pat_valid == 0 && ims_out == 0, "R1 stop clears", {done, pat_valid}, 0);

    // R3 full 65536 passes
    wr_line(0, mk(5, 0, 65535));
    glb(1, 0, 0, 0, 0);
    for (int i = 0; i < 66000 && !done; i++) @(negedge clk);
    chk(word_cnt == 65536, "R3 max repeat count", word_cnt, 65536);
    chk(done == 1, "R10 done after max repeat", done, 1);

    // R3 infinite repeat
    l = mk(7, 2, 0); l.rpt_inf = 1;
    wr_line(0, l);
    glb(1, 0, 0, 0, 0);
    repeat (300) @(negedge clk);
    chk(pat_valid == 1 && done == 0, "R3 infinite keeps running", {pat_valid, done}, 2);
    glb(0, 0, 0, 0, 0);

    // R4 level wait on ev_in[0]
    l = mk(60, 1, 0); l.wait_en = 1; l.wait_c.care = 9'h001; l.wait_c.want = 9'h001;
    wr_line(0, l);
    glb(1, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    chk(pat_valid == 0, "R4 stalled while condition false", pat_valid, 0);
    #1 ev_in = 8'h01;
    @(negedge clk);
    chk(pat_valid == 1 && pat_addr == 60, "R4 first word after hit", pat_addr, 60);
    #1 ev_in = 8'h00;
    glb(0, 0, 0, 0, 0);

    // R6 R8 unconditional jump skips init block; signal line 2
    l = mk(10, 1, 0); l.sig_lvl = 1;
    wr_line(0, l);
    l = mk(20, 0, 0); l.jmp_en = 1; l.jmp_tgt = 4'd1;
    wr_line(1, l);
    glb(1, 0, 1, 2, 0);
    chk(ims_out == 4'b0100, "R8 signal on selected line", ims_out, 4);
    repeat (6) @(negedge clk);
    chk_seq('{10, 11, 20, 20, 20, 20}, "R6 init block runs once");
    chk(ims_out == 4'b0000 && done == 0, "R8 signal follows line", ims_out, 0);
    glb(0, 0, 0, 0, 0);

    // R5 R6 level jump on cross-module bit 8, repeats abandoned
    clear_lines();
    l = mk(0, 1, 3); l.jmp_en = 1; l.jmp_c.care = 9'h100; l.jmp_c.want = 9'h100; l.jmp_tgt = 4'd1;
    wr_line(0, l);
    l = mk(30, 0, 0); l.rpt_inf = 1;
    wr_line(1, l);
    #1 ims_in = 4'b1000;
    glb(1, 0, 1, 0, 3);
    repeat (5) @(negedge clk);
    chk_seq('{0, 1, 30, 30}, "R5 R6 jump on selected cross-module input");
    #1 ims_in = 4'b0000;
    glb(0, 0, 0, 0, 0);

    // R7 edge held until last word
    l = mk(0, 7, 0); l.rpt_inf = 1; l.jmp_en = 1; l.jmp_c.edge_mode = 1;
    l.jmp_c.care = 9'h002; l.jmp_c.want = 9'h002; l.jmp_tgt = 4'd1;
    wr_line(0, l);
    l = mk(50, 0, 0); l.rpt_inf = 1;
    wr_line(1, l);
    glb(1, 0, 1, 0, 0);
    @(negedge clk);
    #1 ev_in = 8'h02;
    repeat (10) @(negedge clk);
    chk_seq('{0, 1, 2, 3, 4, 5, 6, 7, 50}, "R7 held edge jumps at block end");
    #1 ev_in = 8'h00;
    glb(0, 0, 0, 0, 0);

    // R9 manual satisfy ignored then honoured
    clear_lines();
    l = mk(40, 0, 0); l.wait_en = 1; l.wait_c.care = 9'h001; l.wait_c.want = 9'h001;
    wr_line(0, l);
    glb(1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    #1 man_sat = 1; @(negedge clk); #1 man_sat = 0;
    repeat (3) @(negedge clk);
    chk(pat_valid == 0, "R9 man_sat ignored without step", pat_valid, 0);
    glb(1, 1, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk(pat_valid == 0, "R9 waiting in step mode", pat_valid, 0);
    #1 man_sat = 1;
    @(negedge clk);
    chk(pat_valid == 1 && pat_addr == 40, "R9 man_sat satisfies wait", pat_addr, 40);
    #1 man_sat = 0;
    glb(0, 0, 0, 0, 0);

    // random programs checked by the model (R1..R10 together)
    for (int p = 0; p < 12; p++) begin
      for (int i = 0; i < N_LINES; i++) begin
        l = mk($urandom % 1024, $urandom % 4, $urandom % 3);
        l.rpt_inf = ($urandom % 8) == 0;
        l.wait_en = ($urandom % 3) == 0;
        l.wait_c.edge_mode = $urandom % 2;
        l.wait_c.care = VEC_W'(($urandom % 4 == 0) ? 0 : (1 << ($urandom % VEC_W)));
        l.wait_c.want = VEC_W'($urandom);
        l.sig_lvl = $urandom % 2;
        l.jmp_en = ($urandom % 3) == 0;
        l.jmp_c.edge_mode = $urandom % 2;
        l.jmp_c.care = VEC_W'(($urandom % 4 == 0) ? 0 : (1 << ($urandom % VEC_W)));
        l.jmp_c.want = VEC_W'($urandom);
        l.jmp_tgt = LIDX_W'($urandom);
        wr_line(i, l);
      end
      glb(1, $urandom % 2, $urandom % N_LINES, $urandom % N_IMS, $urandom % N_IMS);
      for (int c = 0; c < 250; c++) begin
        @(negedge clk); #1;
        ev_in = EVT_W'($urandom);
        ims_in = N_IMS'($urandom);
        man_sat = ($urandom % 8) == 0;
      end
      #1 ev_in = '0; ims_in = '0; man_sat = 0;
      glb(0, 0, 0, 0, 0);
      chk(pat_valid == 0 && done == 0, "R1 stop after random program", pat_valid, 0);
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule